// File: doc/BRIEF.md
# Timing Mode Control and Alarm Encoder

This block is the supervisory controller of a reference-locked clock system. Two external control pins pick one of four operating modes: free run, lock to reference 1, lock to reference 2, or holdover. From the chosen mode it drives the reference multiplexer select and the holdover enable of the loop. It also reports the mode on a 2-bit status output. A 2-bit alarm code plus a single alarm flag give the health of the loop and of the selected reference.

The loop supplies health flags: a loss-of-lock flag, set when the reference is more than about 17 ppm from nominal; a tune-limit flag; and one loss-of-reference flag for each input. These flags, and the control pins, pass through two-flop synchronizers. A millisecond tick paces a scan, and every register that feeds an output changes only on a scan edge, in the manner of a firmware polling loop. The status output trails the mode by one scan period. Loss-of-reference alarms are qualified across two scans so that a short dropout raises no alarm.

Top module: `timing_mode_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, src_sel is 00, holdover_en is 0, mode_stat is 00, alarm_code is 00 and alarm_flag is 1.
- R2: The mode is taken from {ctl_b, ctl_a}. The value 00 is free run: src_sel 00, holdover_en 0. The value 01 locks to reference 1: src_sel 01. The value 10 locks to reference 2: src_sel 10. The value 11 is holdover: src_sel 00, holdover_en 1. src_sel never shows 11.
- R3: Once settled, mode_stat reads 00 for free run, 01 for reference 1, 10 for reference 2 and 11 for holdover.
- R4: A pin change reaches src_sel after between SYNC+1 and SYNC+SCAN_MS*TICK clock cycles. mode_stat follows exactly one scan period (SCAN_MS ticks) later, which is 2 to about 4 ms with the default 2 ms scan.
- R5: In free run and in holdover, alarm_flag is 1 and alarm_code is 00, whatever the health flags show.
- R6: In a locked mode, alarm_code is 11 on loss of lock. Otherwise it is 10 on a qualified loss of the selected reference, otherwise 01 on tune limit, otherwise 00. alarm_flag is 1 exactly when the code is not 00. A loss on the reference that is not selected has no effect.
- R7: A loss-of-reference alarm rises only after the synchronized loss flag has been seen on two consecutive scans. That is SYNC+SCAN+1 to SYNC+2*SCAN cycles after the flag rises, and a dropout shorter than half a scan raises no alarm.
- R8: A loss-of-reference alarm clears on the first scan that sees the flag low, within SYNC+1 to SYNC+SCAN cycles.
- R9: src_sel, holdover_en, mode_stat, alarm_code and alarm_flag change only on the clock edge that follows a cycle with ms_tick high. When the mode switches to a reference that is already qualified as lost, alarm_code shows 10 at the same edge as src_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| ctl_a | input | 1 | Mode control pin, low bit of the mode code |
| ctl_b | input | 1 | Mode control pin, high bit of the mode code |
| ref_lost | input | 2 | Loss-of-reference flags, bit 0 reference 1, bit 1 reference 2 |
| loop_unlock | input | 1 | Loss-of-lock flag from the loop |
| tune_limit | input | 1 | Oscillator tuning near its range limit |
| src_sel | output | 2 | Reference multiplexer select: 01 ref 1, 10 ref 2, 00 none |
| holdover_en | output | 1 | Loop holds its last frequency |
| mode_stat | output | 2 | Delayed operating-mode status code |
| alarm_code | output | 2 | Prioritised alarm cause |
| alarm_flag | output | 1 | Summary alarm, active high |

## Verification
A mode switch and the qualification of a loss of reference can land on the same scan edge. The alarm must then use the new mode, not the old one. The bench holds reference 2 lost while locked to reference 1, which raises no alarm, then switches to reference 2. At the first sample where src_sel shows 10, alarm_code must already read 10. On the way back to reference 1, the code must clear at the same edge. Sweeps over the inject phase relative to the tick measure the delay windows for mode changes and for loss-of-reference alarms.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

    localparam int NREF = 2;

    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_REF1 = 2'b01,
        MODE_REF2 = 2'b10,
        MODE_HOLD = 2'b11
    } tmc_mode_e;

    typedef enum logic [1:0] {
        ALM_NONE = 2'b00,
        ALM_TUNE = 2'b01,
        ALM_LOR  = 2'b10,
        ALM_LOL  = 2'b11
    } tmc_alarm_e;

    typedef struct packed {
        logic             pin_b;
        logic             pin_a;
        logic [NREF-1:0]  lor;
        logic             lol;
        logic             tvl;
    } tmc_inputs_t;

    typedef struct packed {
        tmc_alarm_e code;
        logic       flag;
    } tmc_alarm_t;

    function automatic tmc_mode_e decode_mode(input logic a, input logic b);
        return tmc_mode_e'({b, a});
    endfunction

    function automatic logic [1:0] mux_code(input tmc_mode_e m);
        case (m)
            MODE_REF1: return 2'b01;
            MODE_REF2: return 2'b10;
            default:   return 2'b00;
        endcase
    endfunction

    function automatic logic selected_lor(input tmc_mode_e m, input logic [NREF-1:0] lor);
        case (m)
            MODE_REF1: return lor[0];
            MODE_REF2: return lor[1];
            default:   return 1'b0;
        endcase
    endfunction

    function automatic tmc_alarm_t encode_alarm(input tmc_mode_e m, input logic lol,
                                                input logic tvl, input logic lor_sel);
        tmc_alarm_t r;
        r.flag = 1'b1;
        r.code = ALM_NONE;
        if (m == MODE_REF1 || m == MODE_REF2) begin
            if (lol)          r.code = ALM_LOL;
            else if (lor_sel) r.code = ALM_LOR;
            else if (tvl)     r.code = ALM_TUNE;
            else              r.code = ALM_NONE;
            r.flag = (r.code != ALM_NONE);
        end
        return r;
    endfunction

endpackage

// File: rtl/tmc_sync.sv
module tmc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tmc_scan.sv
module tmc_scan #(
    parameter int SCAN_MS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    output logic scan
);
    localparam int CW = (SCAN_MS > 1) ? $clog2(SCAN_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SCAN_MS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ms_tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign scan = ms_tick && (cnt == LAST);
endmodule

// File: rtl/tmc_lor_qual.sv
module tmc_lor_qual #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scan,
    input  logic [N-1:0] lor_s,
    output logic [N-1:0] lor_next
);
    logic [N-1:0] seen;

    for (genvar g = 0; g < N; g++) begin : g_ref
        always_ff @(posedge clk) begin
            if (rst)       seen[g] <= 1'b0;
            else if (scan) seen[g] <= lor_s[g];
        end
        // qualified only when the previous scan also saw the loss
        assign lor_next[g] = lor_s[g] & seen[g];
    end
endmodule

// File: rtl/timing_mode_ctrl.sv
module timing_mode_ctrl
    import tmc_pkg::*;
#(
    parameter int SCAN_MS     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ms_tick,
    input  logic            ctl_a,
    input  logic            ctl_b,
    input  logic [NREF-1:0] ref_lost,
    input  logic            loop_unlock,
    input  logic            tune_limit,
    output logic [1:0]      src_sel,
    output logic            holdover_en,
    output logic [1:0]      mode_stat,
    output logic [1:0]      alarm_code,
    output logic            alarm_flag
);
    localparam int IW = $bits(tmc_inputs_t);

    tmc_inputs_t raw_in, syn_in;
    logic        scan;
    logic [NREF-1:0] lor_next;

    tmc_mode_e  mode_q, stat_q, mode_next;
    tmc_alarm_t alarm_q, alarm_next;

    assign raw_in = '{pin_b: ctl_b, pin_a: ctl_a, lor: ref_lost,
                      lol: loop_unlock, tvl: tune_limit};

    tmc_sync #(.W(IW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    tmc_scan #(.SCAN_MS(SCAN_MS)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .ms_tick (ms_tick),
        .scan    (scan)
    );

    tmc_lor_qual #(.N(NREF)) u_lor (
        .clk      (clk),
        .rst      (rst),
        .scan     (scan),
        .lor_s    (syn_in.lor),
        .lor_next (lor_next)
    );

    always_comb begin
        mode_next  = decode_mode(syn_in.pin_a, syn_in.pin_b);
        alarm_next = encode_alarm(mode_next, syn_in.lol, syn_in.tvl,
                                  selected_lor(mode_next, lor_next));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_FREE;
            stat_q  <= MODE_FREE;
            alarm_q <= '{code: ALM_NONE, flag: 1'b1};
        end else if (scan) begin
            mode_q  <= mode_next;
            stat_q  <= mode_q;
            alarm_q <= alarm_next;
        end
    end

    assign src_sel     = mux_code(mode_q);
    assign holdover_en = (mode_q == MODE_HOLD);
    assign mode_stat   = stat_q;
    assign alarm_code  = alarm_q.code;
    assign alarm_flag  = alarm_q.flag;
endmodule

// File: rtl/tmc_checker.sv
module tmc_checker (
    input logic       clk,
    input logic       rst,
    input logic       ms_tick,
    input logic [1:0] src_sel,
    input logic       holdover_en,
    input logic [1:0] mode_stat,
    input logic [1:0] alarm_code,
    input logic       alarm_flag
);
    logic [1:0] cur_mode;
    assign cur_mode = holdover_en ? 2'b11 : src_sel;

    assert_src_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_sel));

    assert_hold_no_ref_R2: assert property (@(posedge clk) disable iff (rst)
        holdover_en |-> (src_sel == 2'b00));

    assert_unlocked_alarm_R5: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b00) |-> (alarm_flag && alarm_code == 2'b00));

    assert_flag_matches_code_R6: assert property (@(posedge clk) disable iff (rst)
        (src_sel != 2'b00) |-> (alarm_flag == (alarm_code != 2'b00)));

    assert_stat_trails_mode_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_stat) |-> (mode_stat == $past(cur_mode)));

    assert_stat_on_scan_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_stat) |-> $past(ms_tick));

    assert_src_on_scan_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_mode) |-> $past(ms_tick));

    assert_alarm_on_scan_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable({alarm_code, alarm_flag}) |-> $past(ms_tick));
endmodule

bind timing_mode_ctrl tmc_checker u_tmc_checker (
    .clk         (clk),
    .rst         (rst),
    .ms_tick     (ms_tick),
    .src_sel     (src_sel),
    .holdover_en (holdover_en),
    .mode_stat   (mode_stat),
    .alarm_code  (alarm_code),
    .alarm_flag  (alarm_flag)
);

// File: tb/timing_mode_ctrl_test.sv
module timing_mode_ctrl_test;
    localparam int SCAN_MS  = 2;
    localparam int TICK_CYC = 10;
    localparam int SCAN_CYC = SCAN_MS * TICK_CYC;
    localparam int SYNC     = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ms_tick = 1'b0;
    logic       ctl_a = 1'b0, ctl_b = 1'b0;
    logic [1:0] ref_lost = 2'b00;
    logic       loop_unlock = 1'b0, tune_limit = 1'b0;
    logic [1:0] src_sel, mode_stat, alarm_code;
    logic       holdover_en, alarm_flag;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    int tcnt    = 0;

    timing_mode_ctrl #(.SCAN_MS(SCAN_MS)) uut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .ctl_a(ctl_a), .ctl_b(ctl_b),
        .ref_lost(ref_lost), .loop_unlock(loop_unlock), .tune_limit(tune_limit),
        .src_sel(src_sel), .holdover_en(holdover_en), .mode_stat(mode_stat),
        .alarm_code(alarm_code), .alarm_flag(alarm_flag)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (rst) begin
            tcnt    <= 0;
            ms_tick <= 1'b0;
        end else begin
            ms_tick <= (tcnt == TICK_CYC - 1);
            tcnt    <= (tcnt == TICK_CYC - 1) ? 0 : tcnt + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        vectors++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic set_mode(input int m);
        ctl_a = m[0];
        ctl_b = m[1];
    endtask

    task automatic settle();
        repeat (6 * SCAN_CYC) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 src_sel in reset", int'(src_sel), 0);
        check("R1 alarm_flag in reset", int'(alarm_flag), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 src_sel", int'(src_sel), 0);
        check("R1 holdover_en", int'(holdover_en), 0);
        check("R1 mode_stat", int'(mode_stat), 0);
        check("R1 alarm_code", int'(alarm_code), 0);
        check("R1 alarm_flag", int'(alarm_flag), 1);

        // exhaustive sweep: every mode against every health-flag pattern (R2 R3 R5 R6)
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 16; f++) begin
                int e_src, e_ho, e_code, e_flag;
                set_mode(m);
                ref_lost    = f[1:0];
                loop_unlock = f[2];
                tune_limit  = f[3];
                settle();
                e_src = (m == 1 || m == 2) ? m : 0;
                e_ho  = (m == 3) ? 1 : 0;
                if (m == 1 || m == 2) begin
                    if (f[2])                 e_code = 3;
                    else if (f[m - 1])        e_code = 2;
                    else if (f[3])            e_code = 1;
                    else                      e_code = 0;
                    e_flag = (e_code != 0) ? 1 : 0;
                end else begin
                    e_code = 0;
                    e_flag = 1;
                end
                check("R2 src_sel", int'(src_sel), e_src);
                check("R2 holdover_en", int'(holdover_en), e_ho);
                check("R3 mode_stat", int'(mode_stat), m);
                check((m == 1 || m == 2) ? "R6 alarm_code" : "R5 alarm_code",
                      int'(alarm_code), e_code);
                check((m == 1 || m == 2) ? "R6 alarm_flag" : "R5 alarm_flag",
                      int'(alarm_flag), e_flag);
            end
        end

        // R4: mode change delays over all phases against the scan
        ref_lost = 2'b00; loop_unlock = 1'b0; tune_limit = 1'b0;
        set_mode(2);
        settle();
        for (int i = 0; i < SCAN_CYC; i++) begin
            int tgt, d, dsrc, dstat;
            repeat (i + 1) @(negedge clk);
            tgt = (i % 2 == 0) ? 1 : 2;
            set_mode(tgt);
            d = 0; dsrc = -1; dstat = -1;
            while (d < 200 && dstat < 0) begin
                @(negedge clk);
                d++;
                if (dsrc < 0 && int'(src_sel) == tgt) dsrc = d;
                if (int'(mode_stat) == tgt) dstat = d;
            end
            check_rng("R4 src_sel delay", dsrc, SYNC + 1, SYNC + SCAN_CYC);
            check("R4 status lag behind src_sel", dstat - dsrc, SCAN_CYC);
        end

        // R7 R8: loss-of-reference on and off delays on reference 1
        set_mode(1);
        settle();
        for (int i = 0; i < 10; i++) begin
            int d;
            repeat (2 * i + 1) @(negedge clk);
            ref_lost[0] = 1'b1;
            d = 0;
            while (d < 200 && alarm_code != 2'b10) begin @(negedge clk); d++; end
            check_rng("R7 LOR alarm on delay", d, SYNC + SCAN_CYC + 1, SYNC + 2 * SCAN_CYC);
            check("R7 alarm_flag with LOR", int'(alarm_flag), 1);
            repeat (i) @(negedge clk);
            ref_lost[0] = 1'b0;
            d = 0;
            while (d < 200 && alarm_code != 2'b00) begin @(negedge clk); d++; end
            check_rng("R8 LOR alarm off delay", d, SYNC + 1, SYNC + SCAN_CYC);
        end

        // R7: dropouts shorter than half a scan raise nothing
        for (int i = 0; i < 10; i++) begin
            int seen;
            seen = 0;
            repeat (i + 1) @(negedge clk);
            ref_lost[0] = 1'b1;
            repeat (SCAN_CYC / 2) begin @(negedge clk); if (alarm_code != 2'b00) seen++; end
            ref_lost[0] = 1'b0;
            repeat (3 * SCAN_CYC) begin @(negedge clk); if (alarm_code != 2'b00) seen++; end
            check("R7 short dropout alarm samples", seen, 0);
        end

        // R9: mode switch onto an already lost reference, alarm at the same edge
        ref_lost = 2'b10;
        set_mode(1);
        settle();
        check("R6 unselected loss ignored", int'(alarm_code), 0);
        begin
            int d, prev;
            set_mode(2);
            d = 0; prev = int'(alarm_code);
            while (d < 200 && src_sel != 2'b10) begin
                prev = int'(alarm_code);
                @(negedge clk); d++;
            end
            check("R9 code before switch", prev, 0);
            check("R9 code at switch to lost ref", int'(alarm_code), 2);
            set_mode(1);
            d = 0;
            while (d < 200 && src_sel != 2'b01) begin @(negedge clk); d++; end
            check("R9 code at switch back", int'(alarm_code), 0);
            check("R9 flag at switch back", int'(alarm_flag), 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule